// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Channel with Scatter

This block moves an incoming byte stream into memory buffers that software posts through a ring of 16-byte descriptors. When a frame starts to arrive and a posted descriptor is free, the channel reads that descriptor. It skips a programmable number of bytes plus a 4-byte header slot in the first buffer, then writes payload bytes one at a time. A frame larger than its first buffer spills into the buffers of the following descriptors, starting at byte 0 of each, and carries no header there. Once the last byte is in, the channel writes a 32-bit status header into the reserved slot. Only then does it move its committed ring pointer past the last descriptor the frame used.

Software controls the channel with a control word, a last-posted pointer (the byte offset just past the last descriptor it has filled) and the ring base address. It reads progress back from two status words. If the ring runs dry in the middle of a frame, the overflow-continue option picks one of two outcomes. With the option set, the channel discards the rest of the frame, flags it and keeps running. With the option clear, it stops and reports an overflow error.

Top module: `rxd_rx_channel`

## Requirements
- R1: While control bit 0 is clear, status0 reads 0 (state code 0, offset 0), s_ready, desc_req and mem_wen stay low. Clearing bit 0 resets the committed offset to 0 and the error code in status1 bits 31:28 to 0.
- R2: While enabled, the channel waits in state code 2 (status0 bits 31:28) and keeps s_ready and desc_req low whenever the committed offset equals last_ptr or no frame is offered.
- R3: A descriptor is read at ring_base plus the current descriptor offset. In desc_data, bits 31:0 are control word 1 with end-of-table at bit 28. Bits 46:32 hold the buffer byte count (ctrl2 bits 14:0). Bits 95:64 hold the buffer address.
- R4: The first payload byte of a frame lands at buffer address + offset + 4, where offset is control bits 7:1. Later bytes follow contiguously until the buffer's byte count is reached.
- R5: Payload that does not fit continues at byte 0 of the next descriptor's buffer, with no header.
- R6: The header is a little-endian 32-bit word at first buffer + offset. Bits 15:0 give the number of payload bytes received, bit 23 is the overflow flag, and bits 27:24 give the descriptors used minus one. All other bits are zero.
- R7: The header is written after the last byte. The committed offset in status0 bits 12:0 changes only after the header write, and then points past the frame's last descriptor.
- R8: After a descriptor whose control word 1 bit 28 is set, the next descriptor is taken at ring offset 0.
- R9: With control bit 10 set, a frame that runs out of descriptors has its remaining bytes accepted and discarded. Its header carries the full byte count and bit 23 set, and the channel then serves the next frame normally.
- R10: With control bit 10 clear, running out of descriptors mid-frame puts the channel in state code 3 with error code 2 in status1 bits 31:28 and s_ready low. It stays there until bit 0 is cleared.
- R11: While a descriptor fetch or a frame is in progress, status0 bits 31:28 read 1, and status1 bits 12:0 give the offset of the descriptor in use.
- R12: Control bit 11 has no effect on the memory writes or the status.
- R13: Each memory write stores one byte. mem_addr is the word-aligned address, exactly one mem_wstrb bit (lane = byte address bits 1:0) is set, and the byte appears on that lane of mem_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control: enable, header offset, overflow-continue, parity-disable |
| last_ptr | input | 13 | Byte offset past the last posted descriptor |
| ring_base | input | 32 | Base address of the descriptor ring |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| desc_req | output | 1 | Descriptor read request, held until desc_ack |
| desc_addr | output | 32 | Descriptor byte address |
| desc_ack | input | 1 | Descriptor data valid |
| desc_data | input | 128 | Descriptor contents |
| mem_wen | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned write address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane strobes |
| status0 | output | 32 | State code [31:28], committed offset [12:0] |
| status1 | output | 32 | Error code [31:28], active descriptor offset [12:0] |

## Verification
The most delicate collision is a frame's last byte arriving in the same cycle that it fills a buffer exactly. The end-of-frame path must win over the move to the next descriptor, or an extra descriptor is consumed and the header count is wrong. Frames sized to end exactly on the first or second buffer boundary provoke this case. The stored header count and the committed offset afterwards show which path was taken. A second case is the descriptor hand-off landing on the last posted descriptor while bytes keep arriving. Both outcomes are judged: the discard path (flag set, full length, channel still serving) and the stop path (ready held low, error code).

// File: rtl/rxd_pkg.sv
// Shared types and constants for the receive descriptor-ring channel.
// Assumes a 32-bit status layout with the state/error code in bits 31:28.
package rxd_pkg;

    typedef enum logic [2:0] {
        S_DIS,
        S_WAIT,
        S_FETCH,
        S_RECV,
        S_NEXT,
        S_DROP,
        S_HDR,
        S_STOP
    } rx_state_t;

    localparam logic [3:0] CODE_DIS  = 4'd0;
    localparam logic [3:0] CODE_ACT  = 4'd1;
    localparam logic [3:0] CODE_IDLE = 4'd2;
    localparam logic [3:0] CODE_STOP = 4'd3;

    localparam logic [3:0] ERR_NONE = 4'd0;
    localparam logic [3:0] ERR_OVF  = 4'd2;

    localparam int CTL_EN_BIT = 0;
    localparam int CTL_OC_BIT = 10;
    localparam int EOT_BIT    = 28;

    // Map an internal state onto the software-visible state code.
    function automatic logic [3:0] state_code(input rx_state_t s);
        case (s)
            S_DIS:   return CODE_DIS;
            S_WAIT:  return CODE_IDLE;
            S_STOP:  return CODE_STOP;
            default: return CODE_ACT;
        endcase
    endfunction

endpackage

// File: rtl/rxd_ctrl_fields.sv
// Splits the control word into enable, header offset and overflow-continue.
// Assumes the offset field sits at bits 7:1; other bits are ignored here.
module rxd_ctrl_fields #(
    parameter int OFS_W = 7
) (
    input  logic [31:0]      ctrl,
    output logic             en,
    output logic             oc,
    output logic [OFS_W-1:0] ofs
);
    import rxd_pkg::*;

    logic unused_ctrl_bits;

    // Field extraction.
    always_comb begin
        en  = ctrl[CTL_EN_BIT];
        oc  = ctrl[CTL_OC_BIT];
        ofs = ctrl[OFS_W:1];
    end

    // Bits with no function in this channel (including parity disable).
    assign unused_ctrl_bits = ^{ctrl[31:CTL_OC_BIT+1], ctrl[CTL_OC_BIT-1:OFS_W+1]};
endmodule

// File: rtl/rxd_hdr_pack.sv
// Packs length, overflow flag and descriptor count into the header word.
// Assumes LEN_W <= 16 and DC_W <= 4 so the fields do not collide.
module rxd_hdr_pack #(
    parameter int LEN_W = 16,
    parameter int DC_W  = 4
) (
    input  logic [LEN_W-1:0] len,
    input  logic             ovf,
    input  logic [DC_W-1:0]  dcnt,
    output logic [31:0]      word
);
    localparam int OVF_POS  = 23;
    localparam int DCNT_POS = 24;

    // Place each field at its fixed bit position.
    always_comb begin
        word = '0;
        word[LEN_W-1:0] = len;
        word[OVF_POS] = ovf;
        word[DCNT_POS +: DC_W] = dcnt;
    end
endmodule

// File: rtl/rxd_byte_lane.sv
// Turns one byte write at a byte address into a word-aligned strobed write.
// Assumes a 32-bit memory port; the byte is replicated on every lane.
module rxd_byte_lane #(
    parameter int AW = 32
) (
    input  logic          wr,
    input  logic [AW-1:0] baddr,
    input  logic [7:0]    bval,
    output logic          wen,
    output logic [AW-1:0] waddr,
    output logic [31:0]   wdata,
    output logic [3:0]    wstrb
);
    localparam int LANES = 4;

    assign wen   = wr;
    assign waddr = {baddr[AW-1:2], 2'b00};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Drive one lane's data and select its strobe.
        assign wdata[8*l +: 8] = bval;
        assign wstrb[l] = wr && (baddr[1:0] == 2'(l));
    end
endmodule

// File: rtl/rxd_rx_channel.sv
// Receive channel: fetches ring descriptors on demand, scatters a frame's
// bytes over their buffers, then writes a status header into the first one.
// Assumes descriptors are returned whole on desc_ack and memory writes
// are always accepted.
module rxd_rx_channel #(
    parameter int AW     = 32,
    parameter int PW     = 13,
    parameter int DESC_B = 16,
    parameter int BC_W   = 15,
    parameter int LEN_W  = 16,
    parameter int DC_W   = 4,
    parameter int OFS_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl_word,
    input  logic [PW-1:0]     last_ptr,
    input  logic [AW-1:0]     ring_base,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              desc_req,
    output logic [AW-1:0]     desc_addr,
    input  logic              desc_ack,
    input  logic [DESC_B*8-1:0] desc_data,
    output logic              mem_wen,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    output logic [31:0]       status0,
    output logic [31:0]       status1
);
    import rxd_pkg::*;

    localparam int DW      = DESC_B * 8;
    localparam int HDR_B   = 4;
    localparam int W1_LSB  = 32;
    localparam int W2_LSB  = 64;
    localparam int STAT_PAD = 28 - PW;

    rx_state_t          st;
    logic [PW-1:0]      cur_off, act_off, nxt_off;
    logic [AW-1:0]      buf_addr, hdr_addr;
    logic [BC_W-1:0]    buf_cnt, pos;
    logic               first, ovf;
    logic [LEN_W-1:0]   len;
    logic [DC_W-1:0]    dcnt;
    logic [3:0]         err;
    logic [1:0]         hidx;

    logic               en, oc;
    logic [OFS_W-1:0]   ofs;
    logic               d_eot;
    logic [BC_W-1:0]    d_cnt;
    logic [AW-1:0]      d_baddr;
    logic               room, acc;
    logic [31:0]        hdr_word;
    logic               wr_byte;
    logic [AW-1:0]      wr_baddr;
    logic [7:0]         wr_val;
    logic               unused_desc_bits;

    rxd_ctrl_fields #(.OFS_W(OFS_W)) ctl_i (
        .ctrl (ctrl_word),
        .en   (en),
        .oc   (oc),
        .ofs  (ofs)
    );

    rxd_hdr_pack #(.LEN_W(LEN_W), .DC_W(DC_W)) hdr_i (
        .len  (len),
        .ovf  (ovf),
        .dcnt (dcnt),
        .word (hdr_word)
    );

    rxd_byte_lane #(.AW(AW)) lane_i (
        .wr    (wr_byte),
        .baddr (wr_baddr),
        .bval  (wr_val),
        .wen   (mem_wen),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .wstrb (mem_wstrb)
    );

    // Descriptor field extraction.
    always_comb begin
        d_eot   = desc_data[EOT_BIT];
        d_cnt   = desc_data[W1_LSB +: BC_W];
        d_baddr = desc_data[W2_LSB +: AW];
    end

    assign unused_desc_bits = ^{desc_data[DW-1:W2_LSB+AW], desc_data[W2_LSB-1:W1_LSB+BC_W],
                                desc_data[31:EOT_BIT+1], desc_data[EOT_BIT-1:0]};

    // Stream handshake: take bytes while buffer space remains or while dropping.
    always_comb begin
        room    = (pos < buf_cnt);
        s_ready = ((st == S_RECV) && room) || (st == S_DROP);
        acc     = s_valid && s_ready;
    end

    // Descriptor read request for the descriptor in use.
    always_comb begin
        desc_req  = (st == S_FETCH);
        desc_addr = ring_base + AW'(act_off);
    end

    // Select the byte to write: payload in receive, header in header phase.
    always_comb begin
        wr_byte  = 1'b0;
        wr_baddr = '0;
        wr_val   = '0;
        if (st == S_RECV && acc) begin
            wr_byte  = 1'b1;
            wr_baddr = buf_addr + AW'(pos);
            wr_val   = s_data;
        end else if (st == S_HDR) begin
            wr_byte  = 1'b1;
            wr_baddr = hdr_addr + AW'(hidx);
            wr_val   = hdr_word[{hidx, 3'b000} +: 8];
        end
    end

    // Status words seen by software.
    always_comb begin
        status0 = {state_code(st), {STAT_PAD{1'b0}}, cur_off};
        status1 = {err, {STAT_PAD{1'b0}}, act_off};
    end

    // Channel sequencer: ring walk, scatter, overflow and header commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_DIS;
            cur_off  <= '0;
            act_off  <= '0;
            nxt_off  <= '0;
            buf_addr <= '0;
            hdr_addr <= '0;
            buf_cnt  <= '0;
            pos      <= '0;
            first    <= 1'b0;
            ovf      <= 1'b0;
            len      <= '0;
            dcnt     <= '0;
            err      <= ERR_NONE;
            hidx     <= '0;
        end else if (!en) begin
            st      <= S_DIS;
            cur_off <= '0;
            err     <= ERR_NONE;
        end else begin
            case (st)
                S_DIS: st <= S_WAIT;
                S_WAIT: begin
                    if (cur_off != last_ptr && s_valid) begin
                        act_off <= cur_off;
                        first   <= 1'b1;
                        len     <= '0;
                        dcnt    <= '0;
                        ovf     <= 1'b0;
                        st      <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (desc_ack) begin
                        buf_addr <= d_baddr;
                        buf_cnt  <= d_cnt;
                        nxt_off  <= d_eot ? '0 : act_off + PW'(DESC_B);
                        if (first) begin
                            hdr_addr <= d_baddr + AW'(ofs);
                            pos      <= BC_W'(ofs) + BC_W'(HDR_B);
                        end else begin
                            pos <= '0;
                            if (dcnt != '1) dcnt <= dcnt + DC_W'(1);
                        end
                        first <= 1'b0;
                        st    <= S_RECV;
                    end
                end
                S_RECV: begin
                    if (!room) begin
                        act_off <= nxt_off;
                        st      <= S_NEXT;
                    end else if (acc) begin
                        len <= len + LEN_W'(1);
                        pos <= pos + BC_W'(1);
                        if (s_last) begin
                            hidx <= '0;
                            st   <= S_HDR;
                        end else if (pos + BC_W'(1) == buf_cnt) begin
                            act_off <= nxt_off;
                            st      <= S_NEXT;
                        end
                    end
                end
                S_NEXT: begin
                    if (act_off == last_ptr) begin
                        if (oc) begin
                            ovf <= 1'b1;
                            st  <= S_DROP;
                        end else begin
                            err <= ERR_OVF;
                            st  <= S_STOP;
                        end
                    end else begin
                        st <= S_FETCH;
                    end
                end
                S_DROP: begin
                    if (acc) begin
                        len <= len + LEN_W'(1);
                        if (s_last) begin
                            hidx <= '0;
                            st   <= S_HDR;
                        end
                    end
                end
                S_HDR: begin
                    hidx <= hidx + 2'd1;
                    if (hidx == 2'd3) begin
                        cur_off <= nxt_off;
                        st      <= S_WAIT;
                    end
                end
                default: st <= S_STOP;
            endcase
        end
    end
endmodule

// File: rtl/rxd_rx_chk.sv
// Temporal checks on the receive channel's ports, bound to every instance.
// Assumes a synchronous active-low reset held for at least one edge.
module rxd_rx_chk #(
    parameter int PW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          s_ready,
    input logic          desc_req,
    input logic          mem_wen,
    input logic [3:0]    mem_wstrb,
    input logic [3:0]    st_code,
    input logic [PW-1:0] cur,
    input logic [3:0]    err_code
);
    AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_code == 4'd0 && cur == '0 && err_code == 4'd0)); // R1
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 4'd0) |-> (!s_ready && !desc_req && !mem_wen)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 4'd2) |-> (!s_ready && !desc_req)); // R2
    AST_COMMIT_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(cur)) |-> $past(mem_wen)); // R7
    AST_STOP_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 4'd3) |-> (err_code == 4'd2 && !s_ready)); // R10
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 4'd3 && en) |=> (st_code == 4'd3)); // R10
    AST_FETCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> (st_code == 4'd1)); // R11
    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wen |-> ($countones(mem_wstrb) == 1)); // R13
endmodule

bind rxd_rx_channel rxd_rx_chk #(.PW(PW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_word[0]),
    .s_ready   (s_ready),
    .desc_req  (desc_req),
    .mem_wen   (mem_wen),
    .mem_wstrb (mem_wstrb),
    .st_code   (status0[31:28]),
    .cur       (status0[PW-1:0]),
    .err_code  (status1[31:28])
);

// File: tb/rxd_rx_channel_tb_top.sv
`timescale 1ns/1ps
module rxd_rx_channel_tb_top;
    localparam int RB = 32'h40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  ctrl_word = '0;
    logic [12:0]  last_ptr = '0;
    logic [31:0]  ring_base = RB;
    logic         s_valid = 1'b0;
    logic         s_ready;
    logic [7:0]   s_data = '0;
    logic         s_last = 1'b0;
    logic         desc_req;
    logic [31:0]  desc_addr;
    logic         desc_ack = 1'b0;
    logic [127:0] desc_data = '0;
    logic         mem_wen;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic [3:0]   mem_wstrb;
    logic [31:0]  status0;
    logic [31:0]  status1;

    int checks = 0;
    int errors = 0;

    logic [7:0]   mem [0:4095];
    logic [127:0] dtab [0:15];

    // Vector: [15:0] length, [22:16] offset, [23] parity-disable bit, [27:24] expected descriptors.
    localparam logic [31:0] VECS [6] = '{
        32'h0106000A, 32'h01860016, 32'h02060017,
        32'h0200003C, 32'h03830046, 32'h010A0001
    };

    rxd_rx_channel dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .last_ptr(last_ptr),
        .ring_base(ring_base), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
        .desc_data(desc_data), .mem_wen(mem_wen), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .status0(status0), .status1(status1)
    );

    always #2.5 clk = ~clk;

    // Memory and descriptor models, evaluated between edges.
    always @(negedge clk) begin
        if (mem_wen) begin
            for (int l = 0; l < 4; l++)
                if (mem_wstrb[l]) mem[mem_addr[11:0] + 12'(l)] = mem_wdata[8*l +: 8];
        end
        if (desc_req && !desc_ack) begin
            desc_ack  = 1'b1;
            desc_data = dtab[4'((desc_addr - RB) >> 4)];
        end else begin
            desc_ack = 1'b0;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all R tags): actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int id, input int i);
        return 8'((id * 53 + i * 7 + 1) & 255);
    endfunction

    // Expected byte address of payload byte i, or -1 when no buffer holds it.
    function automatic int exp_addr(input int off, input int sd, input int i, input int navail);
        int cap1 = 32 - off - 4;
        int j, k;
        if (i < cap1) return 256 * (sd + 1) + off + 4 + i;
        j = i - cap1;
        k = j / 32 + 1;
        if (k >= navail) return -1;
        return 256 * (((sd + k) % 4) + 1) + (j % 32);
    endfunction

    task automatic send_byte(input logic [7:0] d, input bit l, output bit ok);
        s_valid = 1'b1; s_data = d; s_last = l; ok = 1'b0;
        for (int t = 0; t < 100; t++) begin
            if (s_ready) begin
                ok = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_frame(input int id, input int n, output int taken);
        bit ok;
        taken = 0;
        for (int i = 0; i < n; i++) begin
            send_byte(pat(id, i), i == n - 1, ok);
            if (!ok) break;
            taken++;
        end
    endtask

    task automatic check_data(input int id, input int n, input int off, input int sd,
                              input int navail, input string req);
        int bad = 0;
        logic [7:0] a_v = '0, e_v = '0;
        for (int i = 0; i < n; i++) begin
            int a = exp_addr(off, sd, i, navail);
            if (a >= 0 && mem[a] !== pat(id, i)) begin
                if (bad == 0) begin a_v = mem[a]; e_v = pat(id, i); end
                bad++;
            end
        end
        check(bad == 0, req, {24'h0, a_v}, {24'h0, e_v});
    endtask

    function automatic logic [31:0] hdr_at(input int a);
        return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
    endfunction

    initial begin
        int cur_d, taken, off, n, dc;
        bit par, ok;
        logic [31:0] exp_h;
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        for (int d = 0; d < 16; d++)
            dtab[d] = {32'h0, 32'h800 + 32'(d * 16), 32'd32, (d == 3) ? 32'h1000_0000 : 32'h0};
        for (int d = 0; d < 4; d++) dtab[d][95:64] = 32'(256 * (d + 1));

        repeat (4) @(negedge clk);
        check(status0 == 32'h0 && !s_ready && !desc_req && !mem_wen, "R1 reset",
              status0, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(status0 == 32'h0, "R1 disabled after reset", status0, 32'h0);

        // Enabled with nothing posted: idle wait.
        ctrl_word = 32'h1;
        last_ptr  = 13'h0;
        s_valid   = 1'b1;
        repeat (4) @(negedge clk);
        check(status0 == 32'h2000_0000 && !s_ready && !desc_req, "R2 idle, ring empty",
              status0, 32'h2000_0000);
        s_valid = 1'b0;

        // Vector table walk.
        cur_d = 0;
        for (int v = 0; v < 6; v++) begin
            n   = int'(VECS[v][15:0]);
            off = int'(VECS[v][22:16]);
            par = VECS[v][23];
            dc  = int'(VECS[v][27:24]);
            last_ptr  = 13'(((cur_d + 3) % 4) * 16);
            ctrl_word = {20'h0, par, 3'b000, 1'(off >> 6), off[5:0], 1'b1};
            send_byte(pat(v, 0), n == 1, ok);
            if (v == 0)
                check(status0[31:28] == 4'd1 && status1[12:0] == 13'(cur_d * 16),
                      "R11 active state and descriptor", status1, 32'(cur_d * 16));
            for (int i = 1; i < n; i++) send_byte(pat(v, i), i == n - 1, ok);
            repeat (10) @(negedge clk);
            exp_h = {4'h0, 4'(dc - 1), 8'h00, 16'(n)};
            check(hdr_at(256 * (cur_d + 1) + off) == exp_h,
                  par ? "R6 R12 header with bit 11 set" : "R6 header fields",
                  hdr_at(256 * (cur_d + 1) + off), exp_h);
            check_data(v, n, off, cur_d, 3, "R3 R4 R5 R8 R13 payload placement");
            cur_d = (cur_d + dc) % 4;
            check(status0 == {4'h2, 15'h0, 13'(cur_d * 16)}, "R7 R8 committed offset",
                  status0, {4'h2, 15'h0, 13'(cur_d * 16)});
        end

        // Overflow-continue: one descriptor posted, 40 bytes offered.
        last_ptr  = 13'(((cur_d + 1) % 4) * 16);
        ctrl_word = 32'h0000_0401 | (32'd6 << 1);
        send_frame(10, 40, taken);
        repeat (10) @(negedge clk);
        check(taken == 40, "R9 all bytes accepted", 32'(taken), 32'd40);
        check(hdr_at(256 * (cur_d + 1) + 6) == 32'h0080_0028, "R9 overflow header",
              hdr_at(256 * (cur_d + 1) + 6), 32'h0080_0028);
        check_data(10, 40, 6, cur_d, 1, "R9 stored part");
        cur_d = (cur_d + 1) % 4;
        check(status0 == {4'h2, 15'h0, 13'(cur_d * 16)} && status1[31:28] == 4'd0,
              "R9 keeps running", status0, {4'h2, 15'h0, 13'(cur_d * 16)});
        last_ptr = 13'(((cur_d + 1) % 4) * 16);
        send_frame(11, 5, taken);
        repeat (10) @(negedge clk);
        check(hdr_at(256 * (cur_d + 1) + 6) == 32'h0000_0005, "R9 next frame after overflow",
              hdr_at(256 * (cur_d + 1) + 6), 32'h0000_0005);
        cur_d = (cur_d + 1) % 4;

        // Overflow without continue: channel stops.
        last_ptr  = 13'(((cur_d + 1) % 4) * 16);
        ctrl_word = 32'h0000_0001 | (32'd6 << 1);
        send_frame(12, 30, taken);
        check(taken == 22, "R10 bytes taken before stop", 32'(taken), 32'd22);
        check(status0 == {4'h3, 15'h0, 13'(cur_d * 16)} && !s_ready, "R10 stopped state",
              status0, {4'h3, 15'h0, 13'(cur_d * 16)});
        check(status1[31:28] == 4'd2, "R10 overflow error code", status1, 32'h2000_0000);

        // Disable clears state and error.
        ctrl_word = 32'h0;
        repeat (2) @(negedge clk);
        check(status0 == 32'h0 && status1[31:28] == 4'd0 && !s_ready, "R1 disable clears",
              status0, 32'h0);

        summary();
        $finish;
    end
endmodule